// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits on the synchronized SCL and SDA lines of an I2C slave and decides, for each transfer, whether the slave is being addressed. After a Start (SDA falling while SCL is high) it shifts in the first byte MSB first on SCL rising edges. It compares the seven address bits with a programmable primary address and an optional secondary address. It also checks a set of reserved addresses: the general call, the SMBus device default address, the SMBus host address and the SMBus alert response address. Each reserved address has its own enable condition. When the byte matches, the block requests that SDA be pulled low for the whole ninth clock. When that slot ends it raises a sticky match flag and records the read/write bit and a code that says which address matched.

In 10-bit addressing mode only the header byte of the primary address is checked: the five bits 11110 followed by the primary address's two upper bits. The secondary address is not checked in that mode. The second address byte and all data-phase traffic belong to the logic downstream. When no address matches, this block keeps SDA released and ignores the bus until the next Start.

The controller has six states. IDLE waits for a Start. SHIFT collects eight bits. DECIDE waits for the SCL falling edge that follows the eighth bit. ACK holds SDA low through the ninth clock. ADDRESSED is entered after a matched slot. IGNORE is entered after a mismatch. The transitions are as follows. A Start moves any state to SHIFT, so a repeated Start restarts capture. A Stop moves any state to IDLE. SHIFT goes to DECIDE on the eighth SCL rise. DECIDE goes to ACK on the next SCL fall if the byte matched, and to IGNORE otherwise. ACK goes to ADDRESSED on the SCL fall that ends the ninth clock.

Top module: `i2c_addr_match`

## Requirements
- R1: After a Start, bits are sampled on SCL rising edges, MSB first. If the seven address bits equal `own_addr_i` (7-bit mode), `ack_drive_o` rises after the SCL fall that follows the eighth bit. It stays high through the ninth SCL high phase and drops after the ninth SCL fall, and it changes only while SCL is low.
- R2: The secondary address `own2_addr_i` is matched only when `own2_en_i` is 1 and 10-bit mode is off. It reports source code 2.
- R3: With `ten_bit_i` = 1, the only own-address byte that matches is {11110, `own_hi_i`, R/W}, reporting source code 1. Neither `own_addr_i` as a 7-bit address nor the secondary address is acknowledged.
- R4: Address 0000000 (general call) is acknowledged only when `gcall_en_i` = 1, reporting source code 3.
- R5: Address 1100001 is acknowledged only when `smb_mode_i` = 2'b01 (SMBus device mode), reporting source code 4.
- R6: Address 0001000 is acknowledged only when `smb_mode_i` = 2'b10 (SMBus host mode), reporting source code 5.
- R7: Address 0001100 is acknowledged only when `smb_mode_i` = 2'b10 and `alert_en_i` = 1, reporting source code 6.
- R8: On a mismatch, `ack_drive_o` stays low through the ninth clock and all later clocks until the next Start. The match flag and the recorded fields are left unchanged.
- R9: After reset every output is 0. When a matched ACK slot ends, `addr_hit_o` is set, `dir_o` takes the R/W bit (0 = slave receives, 1 = slave transmits) and `src_o` takes the source code (0 none, 1 primary, 2 secondary, 3 general call, 4 device default, 5 host, 6 alert). `addr_hit_o` stays 1 until `clr_hit_i` is pulsed, and a set in the same cycle wins over a clear.
- R10: A Stop (SDA rising while SCL is high) at any point returns the block to idle without an acknowledge. A repeated Start during capture discards the partial byte and restarts capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| own_addr_i | input | 7 | Primary 7-bit address |
| own_hi_i | input | 2 | Upper two bits of the primary 10-bit address |
| own2_addr_i | input | 7 | Secondary 7-bit address |
| own2_en_i | input | 1 | Enables the secondary address |
| ten_bit_i | input | 1 | Selects 10-bit addressing |
| gcall_en_i | input | 1 | Enables the general call address |
| smb_mode_i | input | 2 | 00 plain I2C, 01 SMBus device, 10 SMBus host, 11 plain I2C |
| alert_en_i | input | 1 | Enables the alert response address in host mode |
| clr_hit_i | input | 1 | One-cycle pulse that clears the match flag |
| ack_drive_o | output | 1 | Request to pull SDA low |
| addr_hit_o | output | 1 | Sticky address-matched flag |
| dir_o | output | 1 | Recorded R/W bit of the last match |
| src_o | output | 3 | Source code of the last match |

## Verification
On every cycle, assertions check several properties. The acknowledge request changes only while SCL is low. The match flag holds until a clear and drops after a clear that does not collide with a set. A set flag always carries a non-zero source code. A Stop always lands the controller in IDLE. A match in 10-bit mode never reports the secondary address. The address-decoding rules themselves need the bench's scenarios: which reserved address answers under which mode and enable, and that a mismatch leaves SDA alone for the rest of the transfer. So do the 10-bit header form, the abort by Stop, and the restart by a repeated Start.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int AW     = 7;
    localparam int BYTE_W = AW + 1;
    localparam int HI_W   = 2;
    localparam int PFX_W  = AW - HI_W;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int SRC_W  = 3;
    localparam int MODE_W = 2;

    localparam logic [AW-1:0]    ADR_GCALL   = 7'b0000000;
    localparam logic [AW-1:0]    ADR_SMB_DEV = 7'b1100001;
    localparam logic [AW-1:0]    ADR_SMB_HST = 7'b0001000;
    localparam logic [AW-1:0]    ADR_SMB_ALR = 7'b0001100;
    localparam logic [PFX_W-1:0] TEN_PREFIX  = 5'b11110;

    localparam logic [MODE_W-1:0] MODE_SMB_DEV = 2'b01;
    localparam logic [MODE_W-1:0] MODE_SMB_HST = 2'b10;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE  = 3'd0,
        SRC_OWN1  = 3'd1,
        SRC_OWN2  = 3'd2,
        SRC_GCALL = 3'd3,
        SRC_DEV   = 3'd4,
        SRC_HOST  = 3'd5,
        SRC_ALERT = 3'd6
    } src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DECIDE,
        ST_ACK,
        ST_ADDRESSED,
        ST_IGNORE
    } state_e;

endpackage

// File: rtl/i2c_am_line_events.sv
module i2c_am_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    // idle bus is high on both lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_am_classify.sv
module i2c_am_classify
    import i2c_am_pkg::*;
(
    input  logic [AW-1:0]     addr_i,
    input  logic [AW-1:0]     own_i,
    input  logic [HI_W-1:0]   own_hi_i,
    input  logic [AW-1:0]     own2_i,
    input  logic              own2_en_i,
    input  logic              ten_bit_i,
    input  logic              gcall_en_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              alert_en_i,
    output src_e              src_o
);

    logic [AW-1:0] own_cmp;
    logic          dev_mode;
    logic          host_mode;

    always_comb begin
        own_cmp   = ten_bit_i ? {TEN_PREFIX, own_hi_i} : own_i;
        dev_mode  = (mode_i == MODE_SMB_DEV);
        host_mode = (mode_i == MODE_SMB_HST);
    end

    // primary address first, then secondary, then the reserved set
    always_comb begin
        src_o = SRC_NONE;
        if (addr_i == own_cmp)
            src_o = SRC_OWN1;
        else if (!ten_bit_i && own2_en_i && addr_i == own2_i)
            src_o = SRC_OWN2;
        else if (gcall_en_i && addr_i == ADR_GCALL)
            src_o = SRC_GCALL;
        else if (dev_mode && addr_i == ADR_SMB_DEV)
            src_o = SRC_DEV;
        else if (host_mode && addr_i == ADR_SMB_HST)
            src_o = SRC_HOST;
        else if (host_mode && alert_en_i && addr_i == ADR_SMB_ALR)
            src_o = SRC_ALERT;
    end

endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
    import i2c_am_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise_i,
    input  logic          scl_fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          sda_i,
    input  logic          clr_i,
    input  src_e          cand_i,
    output logic [AW-1:0] addr_o,
    output logic          ack_o,
    output logic          hit_o,
    output logic          dir_o,
    output src_e          src_o
);

    state_e              state_q;
    state_e              state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [BYTE_W-1:0]   shift_q;
    src_e                pend_q;
    src_e                src_q;
    logic                hit_q;
    logic                dir_q;
    logic                set_hit;

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    // next state
    always_comb begin
        state_d = state_q;
        if (stop_i) begin
            state_d = ST_IDLE;
        end else if (start_i) begin
            state_d = ST_SHIFT;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_SHIFT:     if (scl_rise_i && cnt_q == LAST_BIT) state_d = ST_DECIDE;
                ST_DECIDE:    if (scl_fall_i) state_d = (cand_i != SRC_NONE) ? ST_ACK : ST_IGNORE;
                ST_ACK:       if (scl_fall_i) state_d = ST_ADDRESSED;
                ST_ADDRESSED: state_d = ST_ADDRESSED;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // address shifter and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (start_i) begin
            cnt_q   <= '0;
        end else if (state_q == ST_SHIFT && scl_rise_i) begin
            shift_q <= {shift_q[BYTE_W-2:0], sda_i};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // match source latched at the decision edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= SRC_NONE;
        else if (state_q == ST_DECIDE && scl_fall_i)
            pend_q <= cand_i;
    end

    assign set_hit = (state_q == ST_ACK) && scl_fall_i && !stop_i && !start_i;

    // sticky flag with recorded direction and source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            dir_q <= 1'b0;
            src_q <= SRC_NONE;
        end else if (set_hit) begin
            hit_q <= 1'b1;
            dir_q <= shift_q[0];
            src_q <= pend_q;
        end else if (clr_i) begin
            hit_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        ack_o  = (state_q == ST_ACK);
        addr_o = shift_q[BYTE_W-1:1];
        hit_o  = hit_q;
        dir_o  = dir_q;
        src_o  = src_q;
    end

    p_hit_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q && !clr_i |=> hit_q);

    p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !set_hit |=> !hit_q);

    p_src_known_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> src_q != SRC_NONE);

    p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> state_q == ST_IDLE);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [AW-1:0]     own_addr_i,
    input  logic [HI_W-1:0]   own_hi_i,
    input  logic [AW-1:0]     own2_addr_i,
    input  logic              own2_en_i,
    input  logic              ten_bit_i,
    input  logic              gcall_en_i,
    input  logic [MODE_W-1:0] smb_mode_i,
    input  logic              alert_en_i,
    input  logic              clr_hit_i,
    output logic              ack_drive_o,
    output logic              addr_hit_o,
    output logic              dir_o,
    output logic [SRC_W-1:0]  src_o
);

    logic          scl_rise;
    logic          scl_fall;
    logic          start_ev;
    logic          stop_ev;
    logic [AW-1:0] addr_w;
    src_e          cand_w;
    src_e          src_w;

    i2c_am_line_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    i2c_am_classify u_classify (
        .addr_i     (addr_w),
        .own_i      (own_addr_i),
        .own_hi_i   (own_hi_i),
        .own2_i     (own2_addr_i),
        .own2_en_i  (own2_en_i),
        .ten_bit_i  (ten_bit_i),
        .gcall_en_i (gcall_en_i),
        .mode_i     (smb_mode_i),
        .alert_en_i (alert_en_i),
        .src_o      (cand_w)
    );

    i2c_am_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .sda_i      (sda_i),
        .clr_i      (clr_hit_i),
        .cand_i     (cand_w),
        .addr_o     (addr_w),
        .ack_o      (ack_drive_o),
        .hit_o      (addr_hit_o),
        .dir_o      (dir_o),
        .src_o      (src_w)
    );

    assign src_o = src_w;

    p_ack_rise_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_drive_o) |-> !scl_i);

    p_ack_fall_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_drive_o) |-> !scl_i);

    p_ten_no_own2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ten_bit_i && $rose(addr_hit_o) |-> src_o != SRC_OWN2);

endmodule

// File: tb/test_i2c_addr_match.sv
`timescale 1ns/1ps
module test_i2c_addr_match;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_bus;
    logic [6:0] own_addr = 7'h52;
    logic [1:0] own_hi = 2'b10;
    logic [6:0] own2_addr = 7'h33;
    logic       own2_en = 1'b0;
    logic       ten_bit = 1'b0;
    logic       gcall_en = 1'b0;
    logic [1:0] smb_mode = 2'b00;
    logic       alert_en = 1'b0;
    logic       clr_hit = 1'b0;
    logic       ack_drive_o;
    logic       addr_hit_o;
    logic       dir_o;
    logic [2:0] src_o;

    always #2.5 clk = ~clk;

    assign sda_bus = m_sda & ~ack_drive_o;

    i2c_addr_match i_i2c_addr_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .own_addr_i  (own_addr),
        .own_hi_i    (own_hi),
        .own2_addr_i (own2_addr),
        .own2_en_i   (own2_en),
        .ten_bit_i   (ten_bit),
        .gcall_en_i  (gcall_en),
        .smb_mode_i  (smb_mode),
        .alert_en_i  (alert_en),
        .clr_hit_i   (clr_hit),
        .ack_drive_o (ack_drive_o),
        .addr_hit_o  (addr_hit_o),
        .dir_o       (dir_o),
        .src_o       (src_o)
    );

    typedef struct packed {
        logic       ack;
        logic       hit;
        logic       dir;
        logic [2:0] src;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails = 0;
    int    done_cnt = 0;
    int    seen_cnt = 0;
    logic  obs_ack = 1'b0;
    logic  obs_late = 1'b0;
    logic  watch = 1'b0;

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic hw();
        repeat (4) begin
            @(negedge clk);
            if (watch && ack_drive_o) obs_late = 1'b1;
        end
    endtask

    task automatic start_cond();
        m_sda = 1'b1; hw();
        m_scl = 1'b1; hw();
        m_sda = 1'b0; hw();
        m_scl = 1'b0; hw();
    endtask

    task automatic stop_cond();
        m_sda = 1'b0; hw();
        m_scl = 1'b1; hw();
        m_sda = 1'b1; hw();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            m_sda = b[7-i]; hw();
            m_scl = 1'b1;   hw();
            m_scl = 1'b0;   hw();
        end
    endtask

    task automatic ninth();
        m_sda = 1'b1; hw();
        m_scl = 1'b1;
        repeat (2) @(negedge clk);
        obs_ack = ack_drive_o;
        hw();
        m_scl = 1'b0; hw();
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr_hit = 1'b1;
        @(negedge clk) clr_hit = 1'b0;
    endtask

    // driver: pushes the expected result, then runs one addressed transfer
    task automatic run(input logic [7:0] b, input bit clr, input bit e_ack, input bit e_hit,
                       input bit e_dir, input logic [2:0] e_src, input string tag);
        exp_t e;
        if (clr) pulse_clr();
        e.ack = e_ack; e.hit = e_hit; e.dir = e_dir; e.src = e_src;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        obs_late = 1'b0;
        watch = 1'b0;
        start_cond();
        send_bits(b, 8);
        ninth();
        watch = 1'b1;
        send_bits(8'hFF, 9);
        stop_cond();
        watch = 1'b0;
        done_cnt++;
    endtask

    // monitor: pops the expectation and compares with what the design produced
    initial begin
        forever begin
            exp_t  e;
            string t;
            wait (done_cnt > seen_cnt);
            seen_cnt++;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, "ack_slot", {7'b0, obs_ack}, {7'b0, e.ack});
            chk(t, "late_ack", {7'b0, obs_late}, 8'h00);
            chk(t, "hit", {7'b0, addr_hit_o}, {7'b0, e.hit});
            if (e.hit) begin
                chk(t, "dir", {7'b0, dir_o}, {7'b0, e.dir});
                chk(t, "src", {5'b0, src_o}, {5'b0, e.src});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "reset_ack", {7'b0, ack_drive_o}, 8'h00);
        chk("R9", "reset_hit", {7'b0, addr_hit_o}, 8'h00);
        chk("R9", "reset_dir", {7'b0, dir_o}, 8'h00);
        chk("R9", "reset_src", {5'b0, src_o}, 8'h00);

        // primary address, write then read
        run(8'hA4, 1, 1, 1, 0, 3'd1, "R1");
        run(8'hA5, 1, 1, 1, 1, 3'd1, "R9");
        // mismatch without clear keeps the old flag and fields
        run(8'h66, 0, 0, 1, 1, 3'd1, "R9");
        run(8'h66, 1, 0, 0, 0, 3'd0, "R8");
        run(8'h20, 1, 0, 0, 0, 3'd0, "R8");
        // secondary address
        run(8'h66, 1, 0, 0, 0, 3'd0, "R2");
        own2_en = 1'b1;
        run(8'h67, 1, 1, 1, 1, 3'd2, "R2");
        // general call
        run(8'h00, 1, 0, 0, 0, 3'd0, "R4");
        gcall_en = 1'b1;
        run(8'h00, 1, 1, 1, 0, 3'd3, "R4");
        gcall_en = 1'b0;
        // SMBus device default
        run(8'hC2, 1, 0, 0, 0, 3'd0, "R5");
        smb_mode = 2'b01;
        run(8'hC2, 1, 1, 1, 0, 3'd4, "R5");
        run(8'h10, 1, 0, 0, 0, 3'd0, "R6");
        // SMBus host
        smb_mode = 2'b10;
        run(8'h10, 1, 1, 1, 0, 3'd5, "R6");
        run(8'hC2, 1, 0, 0, 0, 3'd0, "R5");
        // alert response
        run(8'h18, 1, 0, 0, 0, 3'd0, "R7");
        alert_en = 1'b1;
        run(8'h19, 1, 1, 1, 1, 3'd6, "R7");
        smb_mode = 2'b01;
        run(8'h18, 1, 0, 0, 0, 3'd0, "R7");
        smb_mode = 2'b00;
        alert_en = 1'b0;
        // 10-bit header
        ten_bit = 1'b1;
        run(8'hF5, 1, 1, 1, 1, 3'd1, "R3");
        run(8'hA4, 1, 0, 0, 0, 3'd0, "R3");
        run(8'h67, 1, 0, 0, 0, 3'd0, "R3");
        run(8'hF1, 1, 0, 0, 0, 3'd0, "R3");
        ten_bit = 1'b0;

        // stop mid-byte, then a byte with no start is ignored
        pulse_clr();
        obs_late = 1'b0;
        watch = 1'b1;
        start_cond();
        send_bits(8'hA4, 4);
        stop_cond();
        send_bits(8'hA4, 8);
        ninth();
        stop_cond();
        watch = 1'b0;
        chk("R10", "abort_ack", {7'b0, obs_ack | obs_late}, 8'h00);
        chk("R10", "abort_hit", {7'b0, addr_hit_o}, 8'h00);

        // repeated start discards partial bits
        pulse_clr();
        start_cond();
        send_bits(8'hFF, 3);
        run(8'hA4, 0, 1, 1, 0, 3'd1, "R10");

        wait (exp_q.size() == 0 && seen_cnt == done_cnt);
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule